// File: doc/BRIEF.md
# Asynchronous Bit-Wide SRAM Controller

This block sits between a clocked request port and an external asynchronous static RAM that holds 65,536 single-bit words. A client offers an access with an address, a write flag and a write bit. The controller accepts it when it is idle and then drives the memory's address, active-low chip select and active-low write strobe, and it controls the direction of the data line. Every phase lasts a whole number of clock cycles, and parameters set those counts so that the device's minimum timings hold at the chosen clock rate.

A write is the period in which chip select and the write strobe are both low. The controller always ends a write by raising the write strobe while chip select stays low. It begins driving the data line one cycle after the strobe falls, so the memory has released the line first. It keeps the data line driven for a configured hold count after the rising edge. A read keeps the write strobe high throughout. The controller captures the data bit in the last cycle of the read and reports it with a one-clock valid pulse.

Top module: `async_bitram_ctrl`

## Requirements
- R1: During and directly after reset, `mem_ce_n` and `mem_we_n` are 1, `mem_dq_oe` is 0, `req_ready` is 1 and `rsp_valid` is 0.
- R2: A request is taken only on a clock edge where `req_valid` and `req_ready` are both 1. After that edge, `req_ready` stays 0 for exactly RD_CYC cycles for a read (`req_write`=0), and for exactly max(WR_CYC, P+DHOLD+1) cycles for a write (`req_write`=1). Here P = max(WE_PULSE, DSETUP+1).
- R3: During a read, `mem_ce_n` is 0 and `mem_we_n` stays 1. In the first cycle after the read, `rsp_valid` is 1 for exactly one clock, and `rsp_rdata` holds the value that `mem_dq_i` had in the last read cycle.
- R4: During a write, `mem_ce_n` falls one cycle before `mem_we_n` falls. `mem_we_n` then stays 0 for exactly P consecutive cycles, and `mem_we_n` is never 0 while `mem_ce_n` is 1.
- R5: `mem_dq_oe` is 0 in the first cycle that `mem_we_n` is 0. It is also 0 whenever `mem_ce_n` is 1. It is 1 for the P-1 (at least DSETUP) cycles that come before `mem_we_n` rises.
- R6: When `mem_we_n` rises, `mem_ce_n` is still 0. From that cycle on, `mem_dq_oe` stays 1 for exactly DHOLD cycles, and then it is released.
- R7: `mem_addr` and `mem_dq_o` keep the values accepted with the request for the whole access, and `mem_addr` holds them until the next request is taken.
- R8: A request offered while `req_ready` is 0 is ignored. It does not change `mem_addr`, and no access starts in the first ready cycle if `req_valid` is 0 by then.
- R9: A read returns the bit most recently written to the same address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Client offers an access |
| req_ready | output | 1 | Controller idle, can take an access |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 16 | Word address |
| req_wdata | input | 1 | Bit to write |
| rsp_valid | output | 1 | One-clock pulse carrying read data |
| rsp_rdata | output | 1 | Bit read from the memory |
| mem_addr | output | 16 | Memory address |
| mem_ce_n | output | 1 | Memory chip select, active low |
| mem_we_n | output | 1 | Memory write strobe, active low |
| mem_dq_o | output | 1 | Bit driven onto the data line |
| mem_dq_oe | output | 1 | 1 = controller drives the data line |
| mem_dq_i | input | 1 | Bit read from the data line |

## Verification
The assertions check, on every cycle, the ordering rules among the strobes: the write strobe only falls inside chip select, the data driver stays off on the cycle the strobe falls and whenever chip select is high, chip select is still low when the write ends, the address holds during a busy period, ready only drops after a request, and valid lasts a single clock. The exact lengths of each phase cannot be seen from one cycle, so the bench measures them: the busy period for reads and writes, the strobe width, the data setup and hold runs. The bench also runs a bus-level memory model, which shows that write data really lands and that requests offered while busy are dropped.

// File: rtl/bitram_pkg.sv
// Shared types and helpers for the bit-wide SRAM controller.
// Assumes nothing beyond constant-function elaboration.
package bitram_pkg;

    typedef enum logic [1:0] {
        OP_IDLE  = 2'd0,
        OP_READ  = 2'd1,
        OP_WRITE = 2'd2
    } bitram_op_e;

    // Larger of two integers, usable in localparam expressions.
    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/bitram_timer.sv
// Access phase counter. It counts clock cycles from 0 to a limit that is
// latched at start. It also exposes its next-state values, so that the
// strobe registers can be loaded in the same cycle without an extra stage.
// Assumes start is only asserted while idle.
module bitram_timer #(
    parameter int CW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic [CW-1:0] last_i,
    output logic          busy_o,
    output logic [CW-1:0] cnt_o,
    output logic          done_o,
    output logic          busy_nxt_o,
    output logic [CW-1:0] cnt_nxt_o
);
    logic [CW-1:0] last_q;

    // Next count and busy flag.
    always_comb begin
        busy_nxt_o = busy_o;
        cnt_nxt_o  = cnt_o;
        if (start_i) begin
            busy_nxt_o = 1'b1;
            cnt_nxt_o  = '0;
        end else if (done_o) begin
            busy_nxt_o = 1'b0;
            cnt_nxt_o  = '0;
        end else if (busy_o) begin
            cnt_nxt_o  = cnt_o + 1'b1;
        end
    end

    assign done_o = busy_o && (cnt_o == last_q);

    // State registers and latched limit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_o <= 1'b0;
            cnt_o  <= '0;
            last_q <= '0;
        end else begin
            busy_o <= busy_nxt_o;
            cnt_o  <= cnt_nxt_o;
            if (start_i) begin
                last_q <= last_i;
            end
        end
    end
endmodule

// File: rtl/bitram_strobe_dec.sv
// Decodes the operation and the phase count into the memory strobe levels.
// Write: count 0 is address setup, counts 1..PW have the strobe low, and
// data is driven from count 2 through the hold cycles. Chip select is
// released after the hold. Read: chip select low, strobe high, no drive.
module bitram_strobe_dec
    import bitram_pkg::*;
#(
    parameter int CW    = 3,
    parameter int PW    = 2,
    parameter int DHOLD = 1
) (
    input  bitram_op_e    op_i,
    input  logic [CW-1:0] cnt_i,
    output logic          ce_n_o,
    output logic          we_n_o,
    output logic          oe_o
);
    localparam int HOLD_END = PW + DHOLD;

    // Strobe levels as a function of phase.
    always_comb begin
        ce_n_o = 1'b1;
        we_n_o = 1'b1;
        oe_o   = 1'b0;
        unique case (op_i)
            OP_READ: begin
                ce_n_o = 1'b0;
            end
            OP_WRITE: begin
                ce_n_o = !(int'(cnt_i) <= HOLD_END);
                we_n_o = !((int'(cnt_i) >= 1) && (int'(cnt_i) <= PW));
                oe_o   = (int'(cnt_i) >= 2) && (int'(cnt_i) <= HOLD_END);
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/async_bitram_ctrl.sv
// Clocked controller for an asynchronous 64K x 1 static RAM.
// It takes one access at a time and shapes the strobes from the parameter
// cycle counts. All memory-side outputs come from registers, so they do not
// glitch. Assumes every timing parameter is at least 1.
module async_bitram_ctrl
    import bitram_pkg::*;
#(
    parameter int AW       = 16,
    parameter int RD_CYC   = 3,
    parameter int WR_CYC   = 4,
    parameter int WE_PULSE = 2,
    parameter int DSETUP   = 2,
    parameter int DHOLD    = 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    output logic          req_ready,
    input  logic          req_write,
    input  logic [AW-1:0] req_addr,
    input  logic          req_wdata,
    output logic          rsp_valid,
    output logic          rsp_rdata,
    output logic [AW-1:0] mem_addr,
    output logic          mem_ce_n,
    output logic          mem_we_n,
    output logic          mem_dq_o,
    output logic          mem_dq_oe,
    input  logic          mem_dq_i
);
    localparam int PW     = imax(WE_PULSE, DSETUP + 1);
    localparam int WR_TOT = imax(WR_CYC, PW + DHOLD + 1);
    localparam int RD_TOT = imax(RD_CYC, 1);
    localparam int SPAN   = imax(WR_TOT, RD_TOT);
    localparam int CW     = $clog2(SPAN + 1);

    logic          accept;
    logic          busy, done, busy_nxt;
    logic [CW-1:0] cnt, cnt_nxt, last_sel;
    bitram_op_e    op_q, op_nxt;
    logic          ce_n_nxt, we_n_nxt, oe_nxt;

    assign req_ready = !busy;
    assign accept    = req_valid && req_ready;
    assign last_sel  = req_write ? CW'(WR_TOT - 1) : CW'(RD_TOT - 1);

    bitram_timer #(.CW(CW)) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (accept),
        .last_i     (last_sel),
        .busy_o     (busy),
        .cnt_o      (cnt),
        .done_o     (done),
        .busy_nxt_o (busy_nxt),
        .cnt_nxt_o  (cnt_nxt)
    );

    // Operation that the strobes will follow in the coming cycle.
    always_comb begin
        if (accept) begin
            op_nxt = req_write ? OP_WRITE : OP_READ;
        end else if (busy_nxt) begin
            op_nxt = op_q;
        end else begin
            op_nxt = OP_IDLE;
        end
    end

    bitram_strobe_dec #(.CW(CW), .PW(PW), .DHOLD(DHOLD)) u_dec (
        .op_i   (op_nxt),
        .cnt_i  (cnt_nxt),
        .ce_n_o (ce_n_nxt),
        .we_n_o (we_n_nxt),
        .oe_o   (oe_nxt)
    );

    // Operation register, address and write-data capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_q     <= OP_IDLE;
            mem_addr <= '0;
            mem_dq_o <= 1'b0;
        end else begin
            op_q <= op_nxt;
            if (accept) begin
                mem_addr <= req_addr;
                mem_dq_o <= req_wdata;
            end
        end
    end

    // Registered memory strobes and data-line enable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem_ce_n  <= 1'b1;
            mem_we_n  <= 1'b1;
            mem_dq_oe <= 1'b0;
        end else begin
            mem_ce_n  <= ce_n_nxt;
            mem_we_n  <= we_n_nxt;
            mem_dq_oe <= oe_nxt;
        end
    end

    // Read-data capture on the last read cycle, with a one-clock valid.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_rdata <= 1'b0;
        end else begin
            rsp_valid <= done && (op_q == OP_READ);
            if (done && (op_q == OP_READ)) begin
                rsp_rdata <= mem_dq_i;
            end
        end
    end
endmodule

// File: rtl/async_bitram_ctrl_checker.sv
// Protocol checker for async_bitram_ctrl. It watches the ports only and is
// attached with the bind statement at the end of this file.
module async_bitram_ctrl_checker #(
    parameter int AW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          req_valid,
    input logic          req_ready,
    input logic          rsp_valid,
    input logic [AW-1:0] mem_addr,
    input logic          mem_ce_n,
    input logic          mem_we_n,
    input logic          mem_dq_oe
);
    // The write strobe is only low inside chip select.
    assert_we_inside_ce_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> !mem_ce_n);

    // Data is not driven on the cycle the write strobe falls.
    assert_no_drive_at_fall_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mem_we_n) |-> !mem_dq_oe);

    // Data is never driven while chip select is high.
    assert_no_drive_unselected_R5: assert property (@(posedge clk) disable iff (!rst_n)
        mem_dq_oe |-> !mem_ce_n);

    // The write ends on the write strobe, with chip select low and data held.
    assert_end_by_we_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_we_n) |-> (!mem_ce_n && mem_dq_oe));

    // The address stays put while busy.
    assert_addr_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!req_ready && $past(!req_ready)) |-> $stable(mem_addr));

    // Busy only follows an offered request.
    assert_busy_needs_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(req_ready) |-> $past(req_valid));

    // Read valid lasts a single clock.
    assert_valid_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    // Reset state of the strobes, checked in the first cycle after reset.
    assert_reset_idle_R1: assert property (@(posedge clk)
        $past(!rst_n) |-> (mem_ce_n && mem_we_n && !mem_dq_oe && req_ready));
endmodule

bind async_bitram_ctrl async_bitram_ctrl_checker #(.AW(AW)) u_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .rsp_valid (rsp_valid),
    .mem_addr  (mem_addr),
    .mem_ce_n  (mem_ce_n),
    .mem_we_n  (mem_we_n),
    .mem_dq_oe (mem_dq_oe)
);

// File: tb/test_async_bitram_ctrl.sv
// Self-checking bench: a bus-level memory model, random and directed accesses,
// and a strobe monitor that measures each phase length.
module test_async_bitram_ctrl;
    localparam int AW = 16, RD_CYC = 3, WR_CYC = 4, WE_PULSE = 2, DSETUP = 2, DHOLD = 1;

    logic clk = 1'b0, rst_n = 1'b0;
    logic req_valid = 1'b0, req_write = 1'b0, req_wdata = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic req_ready, rsp_valid, rsp_rdata, mem_ce_n, mem_we_n, mem_dq_o, mem_dq_oe;
    logic [AW-1:0] mem_addr;
    wire mem_dq_i;

    bit ram [0:65535];
    bit shadow [0:65535];
    int total = 0, bad = 0, cycles = 0;
    bit rd_active = 1'b0;

    always #4 clk = !clk;

    async_bitram_ctrl #(.AW(AW), .RD_CYC(RD_CYC), .WR_CYC(WR_CYC), .WE_PULSE(WE_PULSE),
                        .DSETUP(DSETUP), .DHOLD(DHOLD)) i_async_bitram_ctrl (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .mem_addr(mem_addr),
        .mem_ce_n(mem_ce_n), .mem_we_n(mem_we_n), .mem_dq_o(mem_dq_o),
        .mem_dq_oe(mem_dq_oe), .mem_dq_i(mem_dq_i)
    );

    // Memory model: reads while selected and not writing; the write is taken
    // on the rising write strobe.
    assign mem_dq_i = (!mem_ce_n && mem_we_n) ? ram[mem_addr] : 1'b0;
    always @(posedge mem_we_n) if (!mem_ce_n && mem_dq_oe) ram[mem_addr] <= mem_dq_o;

    function automatic int exp_pw();
        return (WE_PULSE > DSETUP + 1) ? WE_PULSE : DSETUP + 1;
    endfunction
    function automatic int exp_wr_busy();
        return (WR_CYC > exp_pw() + DHOLD + 1) ? WR_CYC : exp_pw() + DHOLD + 1;
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Strobe monitor: measures the strobe width, data setup and data hold.
    int we_run = 0, oe_pre = 0, hold = 0;
    bit hold_on = 1'b0, p_we = 1'b1, p_ce = 1'b1;
    always @(negedge clk) begin
        if (rst_n) begin
            if (hold_on) begin
                if (mem_dq_oe) hold++;
                else begin
                    chk(hold == DHOLD, "R6 hold", hold, DHOLD);
                    hold_on = 1'b0;
                end
            end
            if (!mem_we_n) begin
                we_run++;
                if (mem_dq_oe) oe_pre++;
            end
            if (p_we && !mem_we_n) begin
                chk(!p_ce, "R4 setup", p_ce, 0);
                chk(!mem_dq_oe, "R5 fall", mem_dq_oe, 0);
            end
            if (!p_we && mem_we_n) begin
                chk(we_run == exp_pw(), "R4 width", we_run, exp_pw());
                chk(oe_pre == exp_pw() - 1 && oe_pre >= DSETUP, "R5 setup", oe_pre, exp_pw() - 1);
                chk(!mem_ce_n && mem_dq_oe, "R6 end", mem_ce_n, 0);
                we_run = 0; oe_pre = 0; hold = 1; hold_on = 1'b1;
            end
            if (rd_active && !mem_we_n) chk(1'b0, "R3 strobe", 0, 1);
            if (mem_dq_oe && mem_ce_n) chk(1'b0, "R5 unselected", 1, 0);
            p_we = mem_we_n;
            p_ce = mem_ce_n;
        end
    end

    // Watchdog.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            bad++; total++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 100000);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    // One access: offers it, measures the busy period, presents junk while busy.
    task automatic access(input bit wr, input logic [AW-1:0] a, input bit d, input bit junk);
        int n;
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
        rd_active = !wr;
        @(negedge clk);
        n = 0;
        while (!req_ready) begin
            n++;
            chk(mem_addr == a, "R7 addr", int'(mem_addr), int'(a));
            if (wr) chk(mem_dq_o == d, "R7 data", mem_dq_o, d);
            else    chk(!mem_ce_n, "R3 select", mem_ce_n, 0);
            req_valid = junk; req_write = !wr; req_addr = ~a; req_wdata = !d;
            @(negedge clk);
        end
        req_valid = 1'b0;
        rd_active = 1'b0;
        chk(n == (wr ? exp_wr_busy() : RD_CYC), wr ? "R2 write busy" : "R2 read busy",
            n, wr ? exp_wr_busy() : RD_CYC);
        chk(mem_addr == a, "R8 addr kept", int'(mem_addr), int'(a));
        if (wr) begin
            shadow[a] = d;
            chk(!rsp_valid, "R3 no valid on write", rsp_valid, 0);
        end else begin
            chk(rsp_valid, "R3 valid", rsp_valid, 1);
            chk(rsp_rdata == shadow[a], "R9 data", rsp_rdata, shadow[a]);
        end
        @(negedge clk);
        chk(!rsp_valid, "R3 one clock", rsp_valid, 0);
        chk(mem_ce_n && req_ready, "R8 no start", mem_ce_n, 1);
    endtask

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        chk(mem_ce_n && mem_we_n && !mem_dq_oe && req_ready && !rsp_valid,
            "R1 in reset", {mem_ce_n, mem_we_n, mem_dq_oe, req_ready, rsp_valid}, 5'b11010);
        rst_n = 1'b1;
        @(negedge clk);
        chk(mem_ce_n && mem_we_n && !mem_dq_oe && req_ready && !rsp_valid,
            "R1 after reset", {mem_ce_n, mem_we_n, mem_dq_oe, req_ready, rsp_valid}, 5'b11010);
        // Directed corners: top and bottom address, unwritten read, overwrite.
        access(1'b0, 16'h1234, 1'b0, 1'b0);
        access(1'b1, 16'hFFFF, 1'b1, 1'b1);
        access(1'b0, 16'hFFFF, 1'b0, 1'b1);
        access(1'b1, 16'h0000, 1'b1, 1'b0);
        access(1'b1, 16'h0000, 1'b0, 1'b1);
        access(1'b0, 16'h0000, 1'b1, 1'b0);
        access(1'b1, 16'h8001, 1'b1, 1'b0);
        access(1'b0, 16'h8001, 1'b0, 1'b0);
        // Random mix over a small address pool so reads hit written data.
        for (int i = 0; i < 400; i++) begin
            logic [AW-1:0] a;
            a = ($urandom % 8 == 0) ? AW'($urandom) : AW'($urandom % 16);
            access(1'($urandom), a, 1'($urandom), 1'($urandom));
        end
        repeat (4) @(negedge clk);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule